// File: doc/BRIEF.md
# Video Byte-Stream Component Splitter

This block accepts an 8-bit digital video byte stream carrying YCbCr 4:2:2 samples. Each line is framed by four-byte timing codes: three preamble bytes FF 00 00, then a status byte. Bit 4 of the status byte marks the end of active video (1) or its start (0). Bit 5 marks vertical blanking and bit 6 carries the field. The block tracks these codes and keeps only the active samples. It sorts those samples into luma, blue-difference chroma and red-difference chroma without resampling, and packs each component into 64-bit words. Each component word stream fills its own FIFO.

A downstream transfer engine reads the three FIFOs one word per pop. It waits for a per-component line event, which fires once the words of one full active line of that component have been produced. By default that is 90 words of luma and 45 words of each chroma component. If a FIFO is full when a word arrives, the word is dropped and a sticky overflow flag is set. The line event is still produced, so the engine's line accounting stays aligned with the video.

Top module: `bt656_splitter`

## Requirements
- R1: After reset all three FIFOs report empty, every overflow flag is 0, no line event is asserted and `field_o` is 0.
- R2: Only bytes with `vid_valid` high that arrive between a start code (status bit 4 = 0) and the next end code (status bit 4 = 1) are stored. The FF 00 00 preamble, the status byte, blanking bytes and bytes offered with `vid_valid` low are never stored.
- R3: Active bytes after a start code are assigned in the repeating order Cb, Y, Cr, Y. Bus index 0 is luma, 1 is Cb and 2 is Cr for `pop`, `fifo_empty`, `line_evt` and `ovf_flag`.
- R4: Eight consecutive bytes of one component form one word, little-endian: the first byte sits in bits 7:0 and the eighth byte in bits 63:56.
- R5: Within one line, `line_evt[0]` pulses for one cycle when the 90th luma word is produced. `line_evt[1]` and `line_evt[2]` pulse when the 45th word of their component is produced. Each pulses at most once per line.
- R6: A start code with status bit 5 = 1 (vertical blanking) disables capture until the next start code, so no words and no events are produced.
- R7: The luma FIFO holds 160 words and each chroma FIFO holds 80 words. A word arriving at a full FIFO is dropped, the stored words are kept, the matching `ovf_flag` bit sets and stays set until reset, and line events still fire.
- R8: `field_o` equals status bit 6 of the most recent start code.
- R9: A start code discards any partly packed word and restarts the line word count. A line ended early by an end code raises no event, and its leftover bytes are not combined with the next line.
- R10: Each FIFO presents its oldest word on its data port while not empty. A `pop` pulse removes one word. A `pop` on an empty FIFO leaves it empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_byte | input | 8 | Incoming video byte |
| vid_valid | input | 1 | Qualifies `vid_byte` this cycle |
| pop | input | 3 | Per-component read strobe (0 Y, 1 Cb, 2 Cr) |
| word_y | output | 64 | Oldest luma word |
| word_cb | output | 64 | Oldest Cb word |
| word_cr | output | 64 | Oldest Cr word |
| fifo_empty | output | 3 | Per-component FIFO empty |
| line_evt | output | 3 | Per-component one-cycle line-complete event |
| ovf_flag | output | 3 | Per-component sticky overflow flag |
| field_o | output | 1 | Field bit of the latest start code |

## Verification
The assertions assume that the value FF appears only as the first preamble byte, as legal video guarantees. They also assume a start code is never immediately followed by another timing code before its first active byte. The bench builds every active byte from a formula whose values lie in 1..254 and sends only blanking values 0x80 and 0x10. It places FF only on cycles where `vid_valid` is low, so the detector never sees a stray preamble. Pops are issued only between lines, with the input idle, so the FIFO model in the bench can predict exactly which words a full FIFO drops.

// File: rtl/bt656_split_pkg.sv
package bt656_split_pkg;

    localparam int NUM_COMP   = 3;
    localparam int WORD_BYTES = 8;
    localparam int WORD_BITS  = WORD_BYTES * 8;

    // status byte bit positions (decoded by the timing detector)
    localparam int XY_FIELD_BIT = 6;
    localparam int XY_VBLK_BIT  = 5;
    localparam int XY_EAV_BIT   = 4;

    localparam logic [7:0] PRE_HI = 8'hFF;
    localparam logic [7:0] PRE_LO = 8'h00;

    typedef enum logic [1:0] {
        COMP_Y  = 2'd0,
        COMP_CB = 2'd1,
        COMP_CR = 2'd2
    } comp_e;

    typedef enum logic [1:0] {
        PRE_IDLE = 2'd0,
        PRE_FF   = 2'd1,
        PRE_Z1   = 2'd2,
        PRE_Z2   = 2'd3
    } pre_state_e;

    typedef struct packed {
        logic       valid;
        comp_e      comp;
        logic [7:0] data;
    } cap_beat_t;

    // sample phase after a start code: Cb, Y, Cr, Y
    function automatic comp_e phase_to_comp(input logic [1:0] ph);
        case (ph)
            2'd0:    return COMP_CB;
            2'd2:    return COMP_CR;
            default: return COMP_Y;
        endcase
    endfunction

endpackage

// File: rtl/bt656_trs_detect.sv
module bt656_trs_detect
    import bt656_split_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output cap_beat_t  beat,
    output logic       sol,
    output logic       field
);

    pre_state_e state;
    logic       active;
    logic [1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PRE_IDLE;
            active <= 1'b0;
            phase  <= 2'd0;
            beat   <= '0;
            sol    <= 1'b0;
            field  <= 1'b0;
        end else begin
            beat.valid <= 1'b0;
            sol        <= 1'b0;
            if (in_valid) begin
                case (state)
                    PRE_IDLE: begin
                        if (in_data == PRE_HI) begin
                            state <= PRE_FF;
                        end else if (active) begin
                            beat.valid <= 1'b1;
                            beat.comp  <= phase_to_comp(phase);
                            beat.data  <= in_data;
                            phase      <= phase + 2'd1;
                        end
                    end
                    PRE_FF: state <= (in_data == PRE_LO) ? PRE_Z1 : PRE_IDLE;
                    PRE_Z1: state <= (in_data == PRE_LO) ? PRE_Z2 : PRE_IDLE;
                    PRE_Z2: begin
                        state <= PRE_IDLE;
                        if (in_data[XY_EAV_BIT]) begin
                            active <= 1'b0;
                        end else begin
                            active <= ~in_data[XY_VBLK_BIT];
                            phase  <= 2'd0;
                            sol    <= 1'b1;
                            field  <= in_data[XY_FIELD_BIT];
                        end
                    end
                    default: state <= PRE_IDLE;
                endcase
            end
        end
    end

    // R2: a captured byte is only ever produced while capture was enabled
    assert_capture_in_active_R2: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> $past(active));

    // R2: the start-code cycle itself never yields a sample
    assert_no_capture_on_sol_R2: assert property (@(posedge clk) disable iff (rst)
        sol |-> !beat.valid);

    // R3: the first sample after a start code is blue chroma
    assert_cb_first_R3: assert property (@(posedge clk) disable iff (rst)
        (sol && in_valid && in_data != PRE_HI) |=> (beat.valid -> beat.comp == COMP_CB));

endmodule

// File: rtl/bt656_word_packer.sv
module bt656_word_packer
    import bt656_split_pkg::*;
#(
    parameter int THRESH_WORDS = 90
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sol,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    output logic                 push,
    output logic [WORD_BITS-1:0] word,
    output logic                 evt
);

    localparam int CNT_W = $clog2(THRESH_WORDS + 1);
    localparam int IDX_W = $clog2(WORD_BYTES);

    logic [WORD_BITS-1:0] acc;
    logic [IDX_W-1:0]     idx;
    logic [CNT_W-1:0]     line_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            idx      <= '0;
            line_cnt <= '0;
            push     <= 1'b0;
            word     <= '0;
            evt      <= 1'b0;
        end else begin
            push <= 1'b0;
            evt  <= 1'b0;
            if (sol) begin
                acc      <= '0;
                idx      <= '0;
                line_cnt <= '0;
            end else if (byte_valid) begin
                acc[{idx, 3'b000} +: 8] <= byte_data;
                idx <= idx + 1'b1;
                if (idx == IDX_W'(WORD_BYTES - 1)) begin
                    push <= 1'b1;
                    word <= {byte_data, acc[WORD_BITS-9:0]};
                    if (line_cnt != CNT_W'(THRESH_WORDS)) begin
                        line_cnt <= line_cnt + 1'b1;
                        if (line_cnt == CNT_W'(THRESH_WORDS - 1))
                            evt <= 1'b1;
                    end
                end
            end
        end
    end

    // R5: an event accompanies the word that completes the line quota
    assert_evt_with_push_R5: assert property (@(posedge clk) disable iff (rst)
        evt |-> push);

    // R5: event is a single-cycle pulse
    assert_evt_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

    // R9: a start code leaves no partial word behind
    assert_sol_clears_R9: assert property (@(posedge clk) disable iff (rst)
        sol |=> (idx == '0 && line_cnt == '0));

endmodule

// File: rtl/bt656_comp_fifo.sv
module bt656_comp_fifo #(
    parameter int DEPTH = 160,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         ovf
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_rd, do_wr;

    assign do_rd = rd && (count != '0);
    assign do_wr = wr && ((count != CNT_W'(DEPTH)) || do_rd);
    assign empty = (count == '0);
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr)
                wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_rd)
                rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (do_wr && !do_rd)
                count <= count + 1'b1;
            else if (do_rd && !do_wr)
                count <= count - 1'b1;
            if (wr && !do_wr)
                ovf <= 1'b1;
        end
    end

    // R7: occupancy never exceeds the configured depth
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R7: overflow flag is sticky
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R10: popping an empty FIFO with no write keeps it empty
    assert_pop_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (empty && rd && !wr) |=> empty);

endmodule

// File: rtl/bt656_splitter.sv
module bt656_splitter
    import bt656_split_pkg::*;
#(
    parameter int Y_FIFO_BYTES = 1280,
    parameter int C_FIFO_BYTES = 640,
    parameter int Y_LINE_BYTES = 720,
    parameter int C_LINE_BYTES = 360
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  vid_byte,
    input  logic        vid_valid,
    input  logic [2:0]  pop,
    output logic [63:0] word_y,
    output logic [63:0] word_cb,
    output logic [63:0] word_cr,
    output logic [2:0]  fifo_empty,
    output logic [2:0]  line_evt,
    output logic [2:0]  ovf_flag,
    output logic        field_o
);

    localparam int Y_DEPTH  = Y_FIFO_BYTES / WORD_BYTES;
    localparam int C_DEPTH  = C_FIFO_BYTES / WORD_BYTES;
    localparam int Y_THRESH = Y_LINE_BYTES / WORD_BYTES;
    localparam int C_THRESH = C_LINE_BYTES / WORD_BYTES;

    cap_beat_t            beat;
    logic                 sol;
    logic [WORD_BITS-1:0] rdata [NUM_COMP];

    bt656_trs_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .in_data  (vid_byte),
        .in_valid (vid_valid),
        .beat     (beat),
        .sol      (sol),
        .field    (field_o)
    );

    for (genvar i = 0; i < NUM_COMP; i++) begin : g_comp
        localparam int THR = (i == 0) ? Y_THRESH : C_THRESH;
        localparam int DEP = (i == 0) ? Y_DEPTH  : C_DEPTH;

        logic                 sel;
        logic                 push;
        logic [WORD_BITS-1:0] word;

        assign sel = beat.valid && (beat.comp == comp_e'(2'(i)));

        bt656_word_packer #(.THRESH_WORDS(THR)) u_pack (
            .clk        (clk),
            .rst        (rst),
            .sol        (sol),
            .byte_valid (sel),
            .byte_data  (beat.data),
            .push       (push),
            .word       (word),
            .evt        (line_evt[i])
        );

        bt656_comp_fifo #(.DEPTH(DEP), .W(WORD_BITS)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .wr    (push),
            .wdata (word),
            .rd    (pop[i]),
            .rdata (rdata[i]),
            .empty (fifo_empty[i]),
            .ovf   (ovf_flag[i])
        );
    end

    assign word_y  = rdata[0];
    assign word_cb = rdata[1];
    assign word_cr = rdata[2];

    // R1: nothing is stored or signalled in the cycle after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (fifo_empty == 3'b111 && line_evt == 3'b000 && ovf_flag == 3'b000));

endmodule

// File: tb/tb_bt656_splitter.sv
module tb_bt656_splitter;

    localparam int Y_DEP = 160;
    localparam int C_DEP = 80;
    localparam int Y_THR = 90;
    localparam int C_THR = 45;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  vid_byte;
    logic        vid_valid;
    logic [2:0]  pop;
    logic [63:0] word_y, word_cb, word_cr;
    logic [2:0]  fifo_empty, line_evt, ovf_flag;
    logic        field_o;

    always #5 clk = ~clk;

    bt656_splitter dut (
        .clk(clk), .rst(rst), .vid_byte(vid_byte), .vid_valid(vid_valid),
        .pop(pop), .word_y(word_y), .word_cb(word_cb), .word_cr(word_cr),
        .fifo_empty(fifo_empty), .line_evt(line_evt), .ovf_flag(ovf_flag),
        .field_o(field_o)
    );

    typedef logic [63:0] wq_t [$];
    wq_t expq [3];
    int  n_checks = 0;
    int  n_fail   = 0;
    int  evt_cnt [3];
    int  exp_evt [3];

    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < 3; c++) if (line_evt[c]) evt_cnt[c]++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_val(input int seed, input int i);
        return 8'(1 + ((i * 37 + seed * 11) % 254));
    endfunction

    function automatic int dep_of(input int c);
        return (c == 0) ? Y_DEP : C_DEP;
    endfunction

    function automatic int thr_of(input int c);
        return (c == 0) ? Y_THR : C_THR;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        vid_byte  = b;
        vid_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            vid_byte  = 8'hFF;
            vid_valid = 1'b0;
        end
    endtask

    task automatic send_code(input bit f, input bit v, input bit eav);
        send_byte(8'hFF);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte({1'b1, f, v, eav, 4'h0});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vid_valid = 1'b0; vid_byte = 8'h00; pop = 3'b000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 3; c++) begin
            evt_cnt[c] = 0;
            exp_evt[c] = 0;
            expq[c].delete();
        end
    endtask

    // one line: end code, blanking, start code, active bytes, end code
    task automatic send_line(input int seed, input bit f, input bit v,
                             input int n_act, input bit gaps);
        logic [63:0] acc [3];
        int          nb [3];
        int          nw [3];
        for (int c = 0; c < 3; c++) begin acc[c] = '0; nb[c] = 0; nw[c] = 0; end
        send_code(f, v, 1'b1);
        for (int k = 0; k < 4; k++) begin send_byte(8'h80); send_byte(8'h10); end
        send_code(f, v, 1'b0);
        for (int i = 0; i < n_act; i++) begin
            int c;
            if (gaps && (i % 5 == 3)) idle(1);
            send_byte(byte_val(seed, i));
            c = (i % 4 == 0) ? 1 : ((i % 4 == 2) ? 2 : 0);
            if (!v) begin
                acc[c][nb[c]*8 +: 8] = byte_val(seed, i);
                nb[c]++;
                if (nb[c] == 8) begin
                    if (expq[c].size() < dep_of(c)) expq[c].push_back(acc[c]);
                    nw[c]++;
                    nb[c] = 0;
                    acc[c] = '0;
                end
            end
        end
        send_code(f, v, 1'b1);
        idle(10);
        for (int c = 0; c < 3; c++) if (nw[c] >= thr_of(c)) exp_evt[c]++;
    endtask

    task automatic drain(input string req);
        for (int c = 0; c < 3; c++) begin
            pop[c] = 1'b0;
            @(negedge clk);
            while (!fifo_empty[c]) begin
                logic [63:0] act, exp;
                act = (c == 0) ? word_y : ((c == 1) ? word_cb : word_cr);
                if (expq[c].size() == 0) begin
                    check(1'b0, req, $sformatf("unexpected word comp%0d", c), act, 64'h0);
                end else begin
                    exp = expq[c].pop_front();
                    check(act == exp, req, $sformatf("word comp%0d", c), act, exp);
                end
                pop[c] = 1'b1;
                @(negedge clk);
                pop[c] = 1'b0;
            end
            check(expq[c].size() == 0, req, $sformatf("missing words comp%0d", c),
                  64'(expq[c].size()), 64'h0);
            expq[c].delete();
        end
    endtask

    task automatic check_events(input string req);
        for (int c = 0; c < 3; c++)
            check(evt_cnt[c] == exp_evt[c], req, $sformatf("event count comp%0d", c),
                  64'(evt_cnt[c]), 64'(exp_evt[c]));
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(fifo_empty == 3'b111, "R1", "empty after reset", 64'(fifo_empty), 64'h7);
        check(ovf_flag == 3'b000, "R1", "ovf after reset", 64'(ovf_flag), 64'h0);
        check(line_evt == 3'b000, "R1", "evt after reset", 64'(line_evt), 64'h0);
        check(field_o == 1'b0, "R1", "field after reset", 64'(field_o), 64'h0);
    endtask

    task automatic t_full_line();
        send_line(1, 1'b0, 1'b0, 1440, 1'b0);
        // R3/R4 lane placement of the first words
        check(word_y[7:0] == byte_val(1, 1), "R4", "first Y byte lane 0",
              64'(word_y[7:0]), 64'(byte_val(1, 1)));
        check(word_cb[63:56] == byte_val(1, 28), "R3", "Cb byte lane 7",
              64'(word_cb[63:56]), 64'(byte_val(1, 28)));
        check(word_cr[7:0] == byte_val(1, 2), "R3", "Cr byte lane 0",
              64'(word_cr[7:0]), 64'(byte_val(1, 2)));
        check_events("R5");
        drain("R4");
    endtask

    task automatic t_gapped();
        send_line(2, 1'b0, 1'b0, 1440, 1'b1);
        check_events("R5");
        drain("R2");
    endtask

    task automatic t_vblank();
        send_line(3, 1'b0, 1'b1, 1440, 1'b0);
        check(fifo_empty == 3'b111, "R6", "no words in vblank", 64'(fifo_empty), 64'h7);
        check_events("R6");
    endtask

    task automatic t_field();
        send_line(4, 1'b1, 1'b0, 64, 1'b0);
        check(field_o == 1'b1, "R8", "field set", 64'(field_o), 64'h1);
        drain("R8");
        send_line(5, 1'b0, 1'b0, 64, 1'b0);
        check(field_o == 1'b0, "R8", "field clear", 64'(field_o), 64'h0);
        drain("R8");
    endtask

    task automatic t_short();
        send_line(6, 1'b0, 1'b0, 20, 1'b0);
        check_events("R9");
        send_line(7, 1'b0, 1'b0, 1440, 1'b0);
        check_events("R9");
        drain("R9");
    endtask

    task automatic t_pop_empty();
        @(negedge clk);
        pop = 3'b111;
        @(negedge clk);
        pop = 3'b000;
        @(negedge clk);
        check(fifo_empty == 3'b111, "R10", "pop on empty", 64'(fifo_empty), 64'h7);
        check(ovf_flag == 3'b000, "R10", "no ovf from pop", 64'(ovf_flag), 64'h0);
    endtask

    task automatic t_overflow();
        send_line(8, 1'b0, 1'b0, 1440, 1'b0);
        send_line(9, 1'b0, 1'b0, 1440, 1'b0);
        check(ovf_flag == 3'b111, "R7", "overflow flags", 64'(ovf_flag), 64'h7);
        check_events("R7");
        drain("R7");
        check(ovf_flag == 3'b111, "R7", "overflow sticky", 64'(ovf_flag), 64'h7);
        do_reset();
        @(negedge clk);
        check(ovf_flag == 3'b000, "R1", "reset clears ovf", 64'(ovf_flag), 64'h0);
    endtask

    initial begin
        pop = 3'b000; vid_valid = 1'b0; vid_byte = 8'h00; rst = 1'b1;
        t_reset();
        t_full_line();
        t_gapped();
        t_vblank();
        t_field();
        t_short();
        t_pop_empty();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule